// File: doc/BRIEF.md
# Serial Transceiver Register and Status Interface

This block is the register front end of a serial transceiver. A 32-bit register bus reads and writes a small window of registers: status, a character data register, a baud divisor, three control registers and a guard/prescaler register. On the other side sits a byte-stream link. Received characters arrive with a valid/ready handshake. Transmitted characters leave as a one-cycle strobe carrying a byte. Bit timing, framing and parity belong to other logic. The divisor, control 2, control 3 and guard registers are storage only.

The block keeps three flags in the status register: a character waiting (receive full), transmitter idle (transmit empty) and transmission done. It drives a single level interrupt from those flags, gated by matching enable bits in control 1. The status register takes two kinds of write, selected by the value written. A small value loads the register. A large value is used as a clear mask.

Top module: `uart_regif`

## Requirements
- R1: After reset the status register (byte offset 0x00) reads 0x000000C0. The data register (0x04), baud (0x08), control 1 (0x0C), control 2 (0x10), control 3 (0x14) and guard (0x18) all read 0. `irq` and `tx_strobe` are low.
- R2: `rx_ready` is high exactly when status bit 5 (receive full) is clear. A character offered while bit 5 is set is not taken and does not replace the stored one.
- R3: A character taken on `rx_valid && rx_ready` is stored only when control 1 bit 13 (unit enable) and bit 2 (receiver enable) are both 1. In that case it goes into the data register and status bit 5 is set. Otherwise it is consumed and status and data stay unchanged.
- R4: A read at 0x04 returns the stored character zero-extended, with bits 31:10 always 0. It clears status bit 5 at that clock edge. A character offered in the same cycle is taken only in a later cycle.
- R5: A write to 0x00 with a value at most 0x3FF loads the status register with that value, with bit 7 (transmit empty) forced to 1.
- R6: A write to 0x00 with a value above 0x3FF replaces the status register with its bitwise AND with the value. This can clear any bit, including bit 7.
- R7: A write to 0x04 with a value below 0xF000 raises `tx_strobe` for one cycle after the write edge, with `tx_data` set to the low byte. It also sets status bit 6 (transmission done). A write of 0xF000 or above has no effect.
- R8: `irq` is 1 exactly when one of status bits 5, 6, 7 is 1 and the same bit of control 1 is 1. It follows a control 1 or status change from the cycle after that edge.
- R9: The baud, control 1, control 2, control 3 and guard registers read back the last value written to them.
- R10: Reads at any other byte address in the 0x400 window, including addresses that are not word aligned, return 0. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe, carries read side effects |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_re` |
| rx_valid | input | 1 | Received character offered |
| rx_data | input | CHAR_W | Received character |
| rx_ready | output | 1 | Character can be taken |
| tx_strobe | output | 1 | One-cycle transmit pulse |
| tx_data | output | CHAR_W | Character being transmitted |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with the defaults: ADDR_W = 10, CHAR_W = 8 and CFG_W = 32. A 10-bit address lets the bench reach the far end of the window (0x3FC) and unaligned addresses, so both can be checked as unmapped. An 8-bit character leaves data register bits 9:8 at zero. A full 32-bit status register makes the boundary between loading and masking at 0x3FF/0x400 visible. Full-width control registers let random writes put unit enable and receiver enable in every combination.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
   localparam int unsigned BUS_W     = 32;
   localparam int unsigned DR_W      = 10;
   localparam int unsigned NUM_CFG   = 5;
   localparam int unsigned OFS_SR    = 'h00;
   localparam int unsigned OFS_DR    = 'h04;
   localparam int unsigned OFS_CFG0  = 'h08;
   localparam int unsigned CFG_STEP  = 4;
   localparam int unsigned SR_RXNE   = 5;
   localparam int unsigned SR_TC     = 6;
   localparam int unsigned SR_TXE    = 7;
   localparam int unsigned CR_RXEN   = 2;
   localparam int unsigned CR_UEN    = 13;
   localparam logic [BUS_W-1:0] SR_RST      = 32'h0000_00C0;
   localparam logic [BUS_W-1:0] SR_LOAD_MAX = 32'h0000_03FF;
   localparam logic [BUS_W-1:0] TX_LIMIT    = 32'h0000_F000;
   typedef enum int unsigned {
      CFG_BAUD  = 0,
      CFG_CTL1  = 1,
      CFG_CTL2  = 2,
      CFG_CTL3  = 3,
      CFG_GUARD = 4
   } cfg_idx_e;
endpackage

// File: rtl/uart_regif_cfgbank.sv
module uart_regif_cfgbank
   import uart_regif_pkg::*;
#(
   parameter int unsigned NUM = 5,
   parameter int unsigned W   = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM-1:0]        we,
   input  logic [W-1:0]          wdata,
   output logic [NUM-1:0][W-1:0] q
);
   for (genvar i = 0; i < NUM; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[i] <= '0;
         else if (we[i])
            q[i] <= wdata;
      end
   end
endmodule

// File: rtl/uart_regif_status.sv
module uart_regif_status
   import uart_regif_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [BUS_W-1:0] wdata,
   input  logic             tx_done,
   input  logic             rd_clr,
   input  logic             rx_set,
   output logic [BUS_W-1:0] sr_q
);
   logic [BUS_W-1:0] sr_nxt;

   always_comb begin
      sr_nxt = sr_q;
      if (wr_en) begin
         if (wdata <= SR_LOAD_MAX) begin
            sr_nxt         = wdata;
            sr_nxt[SR_TXE] = 1'b1;
         end else begin
            sr_nxt = sr_q & wdata;
         end
      end
      if (tx_done) sr_nxt[SR_TC]   = 1'b1;
      if (rd_clr)  sr_nxt[SR_RXNE] = 1'b0;
      if (rx_set)  sr_nxt[SR_RXNE] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= SR_RST;
      else        sr_q <= sr_nxt;
   end
endmodule

// File: rtl/uart_regif_rxpath.sv
module uart_regif_rxpath
   import uart_regif_pkg::*;
#(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              full,
   input  logic              unit_en,
   input  logic              rx_en,
   output logic              rx_ready,
   output logic              rx_set,
   output logic [DR_W-1:0]   dr_q
);
   logic take;

   assign rx_ready = !full;
   assign take     = rx_valid && rx_ready;
   assign rx_set   = take && unit_en && rx_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dr_q <= '0;
      else if (rx_set) dr_q <= DR_W'(rx_data);
   end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
   import uart_regif_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned CHAR_W = 8,
   parameter int unsigned CFG_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic              bus_re,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              tx_strobe,
   output logic [CHAR_W-1:0] tx_data,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_SR = ADDR_W'(OFS_SR);
   localparam logic [ADDR_W-1:0] A_DR = ADDR_W'(OFS_DR);

   if (ADDR_W < 5 || ADDR_W > BUS_W) begin : g_bad_addr
      $error("uart_regif: ADDR_W must lie in 5..32");
   end
   if (CHAR_W < 1 || CHAR_W > DR_W) begin : g_bad_char
      $error("uart_regif: CHAR_W must lie in 1..10");
   end
   if (CFG_W <= CR_UEN || CFG_W > BUS_W) begin : g_bad_cfg
      $error("uart_regif: CFG_W must lie in 14..32");
   end

   logic                      sel_sr, sel_dr;
   logic [NUM_CFG-1:0]        cfg_hit;
   logic [NUM_CFG-1:0]        cfg_we;
   logic [NUM_CFG-1:0][CFG_W-1:0] cfg_q;
   logic [CFG_W-1:0]          ctl1_q;
   logic [BUS_W-1:0]          sr_q;
   logic [DR_W-1:0]           dr_q;
   logic                      tx_fire, rd_clr, rx_set;
   logic [BUS_W-1:0]          rd_mux;

   assign sel_sr = (bus_addr == A_SR);
   assign sel_dr = (bus_addr == A_DR);

   for (genvar i = 0; i < NUM_CFG; i++) begin : g_dec
      assign cfg_hit[i] = (bus_addr == ADDR_W'(OFS_CFG0 + i * CFG_STEP));
      assign cfg_we[i]  = bus_we && cfg_hit[i];
   end

   assign ctl1_q  = cfg_q[CFG_CTL1];
   assign tx_fire = bus_we && sel_dr && (bus_wdata < TX_LIMIT);
   assign rd_clr  = bus_re && sel_dr;

   uart_regif_cfgbank #(.NUM(NUM_CFG), .W(CFG_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (bus_wdata[CFG_W-1:0]),
      .q     (cfg_q)
   );

   uart_regif_status u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_we && sel_sr),
      .wdata   (bus_wdata),
      .tx_done (tx_fire),
      .rd_clr  (rd_clr),
      .rx_set  (rx_set),
      .sr_q    (sr_q)
   );

   uart_regif_rxpath #(.CHAR_W(CHAR_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .full     (sr_q[SR_RXNE]),
      .unit_en  (ctl1_q[CR_UEN]),
      .rx_en    (ctl1_q[CR_RXEN]),
      .rx_ready (rx_ready),
      .rx_set   (rx_set),
      .dr_q     (dr_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_strobe <= 1'b0;
         tx_data   <= '0;
      end else begin
         tx_strobe <= tx_fire;
         if (tx_fire) tx_data <= bus_wdata[CHAR_W-1:0];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (sel_sr) rd_mux = sr_q;
      if (sel_dr) rd_mux = BUS_W'(dr_q);
      for (int i = 0; i < NUM_CFG; i++) begin
         if (cfg_hit[i]) rd_mux = BUS_W'(cfg_q[i]);
      end
   end

   assign bus_rdata = bus_re ? rd_mux : '0;
   assign irq = |(sr_q[SR_TXE:SR_RXNE] & ctl1_q[SR_TXE:SR_RXNE]);
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk
   import uart_regif_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned CFG_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic              bus_re,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              tx_strobe,
   input logic              irq,
   input logic [BUS_W-1:0]  sr_q,
   input logic [CFG_W-1:0]  ctl1_q
);
   logic sr_wr, dr_wr_ok, dr_rd;
   assign sr_wr    = bus_we && (bus_addr == ADDR_W'(OFS_SR));
   assign dr_wr_ok = bus_we && (bus_addr == ADDR_W'(OFS_DR)) && (bus_wdata < TX_LIMIT);
   assign dr_rd    = bus_re && (bus_addr == ADDR_W'(OFS_DR));

   // R2: never take a character over an unread one
   p_no_overwrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_ready) |-> !sr_q[SR_RXNE]);

   // R3: receive full rises only from an enabled handshake or a status load
   p_rx_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sr_q[SR_RXNE]) && !$past(sr_wr)) |->
         $past(rx_valid && ctl1_q[CR_UEN] && ctl1_q[CR_RXEN]));

   // R4: data read clears receive full
   p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_rd && !bus_we && !(rx_valid && rx_ready)) |=> !sr_q[SR_RXNE]);

   // R5: small status write keeps transmit empty set
   p_txe_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr && bus_wdata <= SR_LOAD_MAX) |=> sr_q[SR_TXE]);

   // R7: strobe only after an accepted data write
   p_tx_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_strobe |-> $past(dr_wr_ok));

   // R7: accepted data write pulses and sets transmission done
   p_tx_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dr_wr_ok |=> (tx_strobe && sr_q[SR_TC]));

   // R8: interrupt agrees with gated flags
   p_irq_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sr_q[SR_TXE:SR_RXNE] & ctl1_q[SR_TXE:SR_RXNE])) |-> irq);
   p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|(sr_q[SR_TXE:SR_RXNE] & ctl1_q[SR_TXE:SR_RXNE])));
endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_re    (bus_re),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .tx_strobe (tx_strobe),
   .irq       (irq),
   .sr_q      (sr_q),
   .ctl1_q    (ctl1_q)
);

// File: tb/uart_regif_tb.sv
module uart_regif_tb;
   localparam int unsigned ADDR_W = 10;
   localparam int unsigned CHAR_W = 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [ADDR_W-1:0] bus_addr;
   logic              bus_we, bus_re, rx_valid;
   logic [31:0]       bus_wdata, bus_rdata;
   logic [CHAR_W-1:0] rx_data, tx_data;
   logic              rx_ready, tx_strobe, irq;

   always #4 clk = ~clk;

   uart_regif #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .CFG_W(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_strobe(tx_strobe), .tx_data(tx_data), .irq(irq)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;
   logic [31:0] m_sr, m_dr;
   logic [31:0] m_cfg [5];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(logic [ADDR_W-1:0] a);
      case (a)
         10'h000: return m_sr;
         10'h004: return m_dr & 32'h3FF;
         10'h008: return m_cfg[0];
         10'h00C: return m_cfg[1];
         10'h010: return m_cfg[2];
         10'h014: return m_cfg[3];
         10'h018: return m_cfg[4];
         default: return 32'h0;
      endcase
   endfunction

   function automatic string dflt_tag(logic [ADDR_W-1:0] a);
      case (a)
         10'h000: return "R6";
         10'h004: return "R4";
         10'h008, 10'h00C, 10'h010, 10'h014, 10'h018: return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic logic exp_irq();
      return |(m_sr & m_cfg[1] & 32'h0000_00E0);
   endfunction

   task automatic step(logic we, logic re, logic [ADDR_W-1:0] a, logic [31:0] wd,
                       logic rv, logic [7:0] rd, string tag);
      logic en, acc, nt;
      logic [7:0] ntd;
      bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd;
      rx_valid = rv; rx_data = rd;
      #2;
      if (re) chk((tag == "") ? dflt_tag(a) : tag, bus_rdata, exp_read(a));
      chk("R2", {31'b0, rx_ready}, {31'b0, !m_sr[5]});
      en  = m_cfg[1][13] && m_cfg[1][2];
      acc = rv && !m_sr[5];
      nt  = 1'b0;
      ntd = 8'h0;
      if (we) begin
         case (a)
            10'h000: if (wd <= 32'h3FF) m_sr = wd | 32'h80; else m_sr = m_sr & wd;
            10'h004: if (wd < 32'hF000) begin nt = 1'b1; ntd = wd[7:0]; m_sr[6] = 1'b1; end
            10'h008: m_cfg[0] = wd;
            10'h00C: m_cfg[1] = wd;
            10'h010: m_cfg[2] = wd;
            10'h014: m_cfg[3] = wd;
            10'h018: m_cfg[4] = wd;
            default: ;
         endcase
      end
      if (re && a == 10'h004) m_sr[5] = 1'b0;
      if (acc && en) begin m_dr = {24'b0, rd}; m_sr[5] = 1'b1; end
      @(posedge clk);
      @(negedge clk);
      bus_we = 0; bus_re = 0; rx_valid = 0;
      chk("R7", {31'b0, tx_strobe}, {31'b0, nt});
      if (nt) chk("R7", {24'b0, tx_data}, {24'b0, ntd});
      chk("R8", {31'b0, irq}, {31'b0, exp_irq()});
   endtask

   task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
      step(1, 0, a, d, 0, 8'h0, "");
   endtask
   task automatic rdc(logic [ADDR_W-1:0] a, string tag);
      step(0, 1, a, 32'h0, 0, 8'h0, tag);
   endtask
   task automatic rx(logic [7:0] d);
      step(0, 0, 10'h0, 32'h0, 1, d, "");
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [ADDR_W-1:0] alist [10];
      alist = '{10'h000, 10'h004, 10'h008, 10'h00C, 10'h010,
                10'h014, 10'h018, 10'h01C, 10'h3FC, 10'h002};
      rst_n = 0; bus_we = 0; bus_re = 0; bus_addr = '0; bus_wdata = '0;
      rx_valid = 0; rx_data = '0;
      m_sr = 32'hC0; m_dr = 0;
      for (int i = 0; i < 5; i++) m_cfg[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R1: reset contents
      chk("R1", {31'b0, irq}, 32'h0);
      chk("R1", {31'b0, tx_strobe}, 32'h0);
      for (int i = 0; i < 7; i++) rdc(alist[i], "R1");

      // R9: storage registers
      wr(10'h008, 32'hDEAD_BEEF); wr(10'h010, 32'h1234_5678);
      wr(10'h014, 32'hFFFF_0000); wr(10'h018, 32'h0000_00A5);
      for (int i = 2; i < 7; i++) rdc(alist[i], "R9");

      // R10: unmapped window addresses
      wr(10'h01C, 32'hFFFF_FFFF); wr(10'h3FC, 32'h0); wr(10'h002, 32'h55);
      rdc(10'h01C, "R10"); rdc(10'h3FC, "R10"); rdc(10'h002, "R10");
      for (int i = 0; i < 7; i++) rdc(alist[i], "R10");

      // R3: dropped characters with partial enables
      wr(10'h00C, 32'h0); rx(8'h5A); rdc(10'h000, "R3"); rdc(10'h004, "R3");
      wr(10'h00C, 32'h2000); rx(8'h5B); rdc(10'h000, "R3"); rdc(10'h004, "R3");
      wr(10'h00C, 32'h0004); rx(8'h5C); rdc(10'h000, "R3"); rdc(10'h004, "R3");

      // R2/R4: store, refuse overwrite, read clears
      wr(10'h00C, 32'h2024);
      rx(8'h3C);
      step(0, 0, 10'h0, 0, 1, 8'h77, "");
      step(0, 1, 10'h004, 0, 1, 8'h77, "R4");
      rdc(10'h000, "R4");
      rx(8'h77);
      rdc(10'h004, "R2");

      // R7: transmit and limit
      wr(10'h004, 32'h0000_01A5); rdc(10'h000, "R7");
      wr(10'h000, 32'h0);
      wr(10'h004, 32'h0000_F000); rdc(10'h000, "R7");
      wr(10'h004, 32'h0000_EFFF); rdc(10'h000, "R7");

      // R5: small status loads
      wr(10'h000, 32'h005); rdc(10'h000, "R5");
      wr(10'h000, 32'h3FF); rdc(10'h000, "R5");
      wr(10'h000, 32'h000); rdc(10'h000, "R5");

      // R6: mask writes
      wr(10'h000, 32'h3E0); wr(10'h000, 32'hFFFF_FFBF); rdc(10'h000, "R6");
      wr(10'h000, 32'h0000_0400); rdc(10'h000, "R6");
      wr(10'h000, 32'hFFFF_0000); rdc(10'h000, "R6");

      // R8: interrupt follows control 1
      wr(10'h000, 32'h0);
      wr(10'h00C, 32'h0000_0080); chk("R8", {31'b0, irq}, 32'h1);
      wr(10'h00C, 32'h0000_0040); chk("R8", {31'b0, irq}, 32'h0);

      // random mix
      void'($urandom(32'd20240611));
      for (int n = 0; n < 4000; n++) begin
         logic [ADDR_W-1:0] a;
         logic [31:0] d;
         int op;
         a  = alist[$urandom_range(0, 9)];
         op = $urandom_range(0, 2);
         case ($urandom_range(0, 3))
            0: d = $urandom_range(0, 32'h3FF);
            1: d = $urandom | 32'h400;
            2: d = $urandom_range(32'hEF00, 32'hF100);
            default: d = $urandom;
         endcase
         if (a == 10'h00C && $urandom_range(0, 1) == 1) d = d | 32'h2004;
         step(op == 0, op == 1, a, d, $urandom_range(0, 1) == 1,
              8'($urandom), "");
      end

      done = 1;
      summary();
      $finish;
   end
endmodule